// File: doc/BRIEF.md
# Dual-Mode FM0 / Manchester Line Encoder

This block turns a serial bit stream into a DC-balanced two-level line code. Each data bit becomes two half-symbols: a first half and a second half. A mode input picks one of two codes. In FM0 (bi-phase space) the level always flips at a bit boundary, and it flips again mid-bit only for a data 0. In Manchester the first half carries the inverse of the bit and the second half carries the bit itself.

Both codes run through one shared datapath. It holds a single stored bit, which is the second half of the previous FM0 symbol, and uses one multiplexer, one XOR-type gate and one shared inversion. Manchester coding reuses the FM0 path by holding the stored bit at zero through a clear input. That clear input is kept apart from the mode select so that it can also act as the initializer of the FM0 state.

The block runs on a system clock at twice the bit rate. A producer raises `bitValid` with `dataIn` and `modeSel`. The block accepts a bit when it is idle, or in the last cycle of the bit already in flight, so a stream of bits can be sent back to back. The coded level is a registered output, so it carries no glitch at the half-bit switch.

Top module: `dual_biphase_encoder`

## Requirements
- R1: While `rstN` is low and right after it is released, `lineOut` is 0, the stored FM0 bit is 0 and no bit is in progress.
- R2: In FM0 mode (`modeSel`=0) the first half-symbol of a bit is the inverse of the stored bit. With `clr` low, it is therefore the inverse of the previous bit's second half, so every FM0 bit boundary shows a level change.
- R3: In FM0 mode the second half-symbol equals the stored bit XOR the data bit. A data 0 gives a level change between the halves, and a data 1 gives none. The stored bit takes the second half at the end of the bit.
- R4: In Manchester mode (`modeSel`=1, with `clr` held high) the first half-symbol is the inverse of the data bit and the second half-symbol is the data bit.
- R5: A bit is accepted at a clock edge where `bitValid` is 1 and the block is idle or in the second-half cycle. Its first half appears on `lineOut` one clock after acceptance and its second half two clocks after. Until then `lineOut` keeps its previous value.
- R6: `bitValid`, `dataIn` and `modeSel` are ignored during the first-half cycle of a bit in progress.
- R7: `clr` high at a clock edge forces the stored bit to 0, taking priority over the end-of-bit capture. A first FM0 bit coded with `clr` high therefore starts with the half-symbol 1.
- R8: When no bit is in progress, `lineOut` holds its last level.
- R9: The code mode is latched together with the data bit, so a change of `modeSel` in the middle of a bit does not affect that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at twice the bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the stored FM0 bit; held high for Manchester coding |
| modeSel | input | 1 | Code select, latched with each bit: 0 FM0, 1 Manchester |
| bitValid | input | 1 | Strobe offering `dataIn` for acceptance |
| dataIn | input | 1 | Data bit, latched when accepted |
| lineOut | output | 1 | Registered coded half-symbol |

## Verification
The Manchester checks assume that `clr` is held high for a Manchester bit, from the edge that accepts it to its end, so the stored bit is zero when both halves are formed. The FM0 checks assume `clr` stays low between the two halves of a bit. The stimulus drives `clr` with each bit and holds it until the next bit is offered, so Manchester bits always carry `clr`=1. FM0 bits that test the clear path start a fresh run instead of interrupting a bit in progress.

// File: rtl/biphase_pkg.sv
package biphase_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_t;

  typedef struct packed {
    logic load;        // latch data bit and mode at this edge
    logic firstHalf;   // first half-symbol is formed in this cycle
    logic secondHalf;  // second half-symbol is formed, stored bit captured
  } strobe_t;

endpackage

// File: rtl/biphase_ctrl.sv
module biphase_ctrl
  import biphase_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitValid,
  output strobe_t strb
);

  phase_t phase;
  phase_t phaseNext;
  logic   accept;

  // a new bit may enter while idle or during the closing half of the current bit
  assign accept = bitValid && (phase != PH_FIRST);

  always_comb begin
    if (accept)
      phaseNext = PH_FIRST;
    else if (phase == PH_FIRST)
      phaseNext = PH_SECOND;
    else
      phaseNext = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      phase <= PH_IDLE;
    else
      phase <= phaseNext;
  end

  always_comb begin
    strb.load       = accept;
    strb.firstHalf  = (phase == PH_FIRST);
    strb.secondHalf = (phase == PH_SECOND);
  end

  AST_FIRST_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> strb.firstHalf); // R5

  AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    strb.firstHalf |=> strb.secondHalf); // R5

  AST_HALVES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.firstHalf, strb.secondHalf})); // R5

endmodule

// File: rtl/biphase_datapath.sv
module biphase_datapath
  import biphase_pkg::*;
#(
  parameter bit   BALANCED_PATH = 1'b1,
  parameter logic RESET_LEVEL   = 1'b0
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    clr,
  input  logic    modeSel,
  input  logic    dataIn,
  input  strobe_t strb,
  output logic    lineOut
);

  logic xReg;
  logic modeReg;
  logic bPrev;
  logic muxA;
  logic halfVal;

  // bit and mode are captured together so a mid-bit mode change cannot leak in
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xReg    <= 1'b0;
      modeReg <= 1'b0;
    end else if (strb.load) begin
      xReg    <= dataIn;
      modeReg <= modeSel;
    end
  end

  // the one stored state bit; clear wins over the end-of-bit capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      bPrev <= 1'b0;
    else if (clr)
      bPrev <= 1'b0;
    else if (strb.secondHalf)
      bPrev <= halfVal;
  end

  // shared operand select: previous half for FM0, data for Manchester
  assign muxA = modeReg ? xReg : bPrev;

  generate
    if (BALANCED_PATH) begin : g_balanced
      logic bXnor;
      logic preSel;
      assign bXnor   = ~(bPrev ^ xReg);
      assign preSel  = strb.firstHalf ? muxA : bXnor;
      assign halfVal = ~preSel;
    end else begin : g_direct
      logic aVal;
      logic bVal;
      assign aVal    = ~muxA;
      assign bVal    = bPrev ^ xReg;
      assign halfVal = strb.firstHalf ? aVal : bVal;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      lineOut <= RESET_LEVEL;
    else if (strb.firstHalf || strb.secondHalf)
      lineOut <= halfVal;
  end

  AST_FM0_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    strb.firstHalf && !modeReg && $past(strb.secondHalf) && !$past(clr)
    |=> lineOut != $past(lineOut)); // R2

  AST_FM0_MIDBIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.secondHalf && !modeReg && !$past(clr)
    |=> (lineOut ^ $past(lineOut)) == !$past(xReg)); // R3

  AST_MANCH_MIDBIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.secondHalf && modeReg && !bPrev
    |=> lineOut == $past(xReg) && lineOut != $past(lineOut)); // R4

  AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.firstHalf |=> $stable(xReg) && $stable(modeReg)); // R6

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> !bPrev); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.firstHalf && !strb.secondHalf |=> $stable(lineOut)); // R8

endmodule

// File: rtl/dual_biphase_encoder.sv
module dual_biphase_encoder
  import biphase_pkg::*;
#(
  parameter bit   BALANCED_PATH = 1'b1,
  parameter logic RESET_LEVEL   = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic modeSel,
  input  logic bitValid,
  input  logic dataIn,
  output logic lineOut
);

  strobe_t strb;

  biphase_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitValid (bitValid),
    .strb     (strb)
  );

  biphase_datapath #(
    .BALANCED_PATH (BALANCED_PATH),
    .RESET_LEVEL   (RESET_LEVEL)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .clr     (clr),
    .modeSel (modeSel),
    .dataIn  (dataIn),
    .strb    (strb),
    .lineOut (lineOut)
  );

endmodule

// File: tb/dual_biphase_encoder_test.sv
`timescale 1ns/1ps
module dual_biphase_encoder_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clr = 1'b0;
  logic modeSel = 1'b0;
  logic bitValid = 1'b0;
  logic dataIn = 1'b0;
  logic lineOut;

  int    nChecked = 0;
  int    nFailed  = 0;
  bit    done     = 1'b0;
  logic  lastOut  = 1'b0;   // level the line should show now
  logic  refB     = 1'b0;   // model of the remembered second half
  string lastTag  = "R5 hold";

  always #2.5 clk = ~clk;

  dual_biphase_encoder uut (
    .clk      (clk),
    .rstN     (rstN),
    .clr      (clr),
    .modeSel  (modeSel),
    .bitValid (bitValid),
    .dataIn   (dataIn),
    .lineOut  (lineOut)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    nChecked++;
    if (act !== exp) begin
      nFailed++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nFailed);
    $finish;
  endtask

  // called at a falling edge; offers one bit and follows it through both halves
  task automatic sendBit(input logic x, input logic m, input logic c, input bit noisy);
    logic a;
    logic b;
    bitValid = 1'b1;
    dataIn   = x;
    modeSel  = m;
    clr      = c;
    if (c) refB = 1'b0;
    if (m) begin
      a = ~x;
      b = x;
    end else begin
      a = ~refB;
      b = refB ^ x;
    end
    @(negedge clk);
    // accepted; the line still shows the previous level (R5)
    check(lastTag, lineOut, lastOut);
    if (noisy) begin
      bitValid = 1'b1;   // R6: must be ignored in the first half
      dataIn   = ~x;
      modeSel  = ~m;     // R9: must not reach this bit
    end else begin
      bitValid = 1'b0;
    end
    @(negedge clk);
    if (noisy)
      check(m ? "R6 R9 first half under noise (R4)" : "R6 R9 first half under noise (R2)", lineOut, a);
    else
      check(m ? "R4 first half" : "R2 first half", lineOut, a);
    if (!m && !c) check("R2 boundary transition", lineOut != lastOut, 1'b1);
    if (!m && c)  check("R7 cleared start is 1", lineOut, 1'b1);
    bitValid = 1'b0;
    dataIn   = x;
    modeSel  = m;
    lastOut  = b;
    refB     = b;
    if (noisy)
      lastTag = m ? "R6 R9 second half (R4)" : "R6 R9 second half (R3)";
    else
      lastTag = m ? "R4 second half" : "R3 second half";
  endtask

  task automatic idle(input int n);
    bitValid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clr) refB = 1'b0;
      check((i == 0) ? lastTag : "R8 idle hold", lineOut, lastOut);
    end
    lastTag = "R8 idle hold";
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFailed++;
      $display("FAIL R5 watchdog: actual=running expected=finished");
      report();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset level", lineOut, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    check("R1 after release", lineOut, 1'b0);
    idle(3);

    // FM0 stream from the reset state, back to back
    sendBit(1'b1, 1'b0, 1'b0, 1'b0);
    sendBit(1'b0, 1'b0, 1'b0, 1'b0);
    sendBit(1'b0, 1'b0, 1'b0, 1'b0);
    sendBit(1'b1, 1'b0, 1'b0, 1'b0);
    sendBit(1'b1, 1'b0, 1'b0, 1'b0);
    sendBit(1'b0, 1'b0, 1'b0, 1'b0);
    sendBit(1'b1, 1'b0, 1'b0, 1'b0);
    sendBit(1'b0, 1'b0, 1'b0, 1'b0);
    idle(4);

    // gap then resume: state survives idle
    sendBit(1'b0, 1'b0, 1'b0, 1'b0);
    sendBit(1'b1, 1'b0, 1'b0, 1'b0);
    idle(2);

    // fresh run after clear (R7)
    sendBit(1'b0, 1'b0, 1'b1, 1'b0);
    sendBit(1'b1, 1'b0, 1'b0, 1'b0);
    sendBit(1'b0, 1'b0, 1'b0, 1'b0);
    idle(2);
    sendBit(1'b1, 1'b0, 1'b1, 1'b0);
    sendBit(1'b1, 1'b0, 1'b0, 1'b0);

    // Manchester with clr held
    sendBit(1'b1, 1'b1, 1'b1, 1'b0);
    sendBit(1'b0, 1'b1, 1'b1, 1'b0);
    sendBit(1'b1, 1'b1, 1'b1, 1'b0);
    sendBit(1'b1, 1'b1, 1'b1, 1'b0);
    sendBit(1'b0, 1'b1, 1'b1, 1'b0);
    sendBit(1'b0, 1'b1, 1'b1, 1'b0);
    idle(3);
    sendBit(1'b1, 1'b1, 1'b1, 1'b1);
    sendBit(1'b0, 1'b1, 1'b1, 1'b1);

    // back to FM0 straight from Manchester
    sendBit(1'b0, 1'b0, 1'b0, 1'b0);
    sendBit(1'b1, 1'b0, 1'b0, 1'b1);
    sendBit(1'b0, 1'b0, 1'b0, 1'b1);
    sendBit(1'b1, 1'b0, 1'b0, 1'b0);
    sendBit(1'b0, 1'b0, 1'b0, 1'b1);
    idle(4);

    done = 1'b1;
    report();
  end

endmodule